// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to 32 external interrupt pins and turns the events it sees on them into interrupt requests for a parent interrupt controller. Each pin has its own sense selection: low level, high level, falling edge, rising edge or both edges. Every pin passes through a two-stage synchroniser. Edges are found by comparing the synchronised level with its sample from the previous clock. A detected event sets a sticky per-pin detect bit. Software clears that bit by writing a one to it.

Software reaches the block over a plain 32-bit read/write register bus. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The bus provides:
- a per-pin enable mask, with separate write-one-to-set and write-one-to-clear locations;
- the detect status;
- a monitor of the synchronised pin levels;
- a masked request view.

Each pin drives its own interrupt output, high while that pin is both detected and enabled.

Top module: `extint_ctrl`

## Requirements
- R1: After reset the enable mask is 0, all detect bits are 0, `irq_o` is 0, and every present pin's configuration register reads 0x00000002 (high-level sense).
- R2: The configuration register of pin n sits at offset 0x180 + 4·n. It keeps and reads back all 32 written bits. Only bits 3:0 select the sense.
- R3: Sense code 0x2 (high level) sets the detect bit while the synchronised pin is high. A clear written while the pin stays high leaves the bit set. Once the pin is low, the bit stays set until cleared.
- R4: Sense code 0x1 (low level) sets the detect bit while the synchronised pin is low.
- R5: Sense code 0x8 (rising edge) sets the detect bit once per 0→1 transition. A pin that stays high does not set the bit again after a clear, and a 1→0 transition sets nothing.
- R6: Sense code 0x4 sets the detect bit on a 1→0 transition only. Sense code 0xC sets it on both transitions.
- R7: Any other sense code value in bits 3:0 (for example 0x3) detects nothing.
- R8: Offset 0x100 reads the detect status. Writing 1 to a bit clears it and writing 0 leaves it unchanged. If an event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: Writing 1 to a bit at offset 0x08 enables that pin. Writing 1 to a bit at offset 0x04 disables it. Zero bits change nothing. Offset 0x04 reads the enable mask.
- R10: Offset 0x00 reads detect AND enable. `irq_o[n]` is high exactly while that request bit is set.
- R11: Offset 0x104 reads the synchronised pin levels. A pin change is visible there after two clock edges.
- R12: Bits for pins at or above `NUM_PINS` read 0 and ignore writes. Configuration offsets of absent pins read 0.
- R13: A pin event appears in the detect status on the third clock edge after the pin changes: two synchroniser stages, then the detect register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | External interrupt pins, asynchronous |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` |
| irq_o | output | NUM_PINS | Per-pin interrupt requests to the parent controller |

## Verification
On every cycle the assertions check four things:
- outputs never fire for a disabled pin;
- detect bits fall only in a cycle with a clear write;
- enable-set and enable-clear writes take hold on the next edge;
- the level monitor lags the pins by exactly two edges.

The sense-mode behaviour can only be shown by the bench's scenarios. That covers level re-triggering against edge single-shot, codes that detect nothing, the race where an event and a clear of the same bit coincide, and configuration read-back.

// File: rtl/extint_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the external interrupt controller.
// Assumes a 12-bit byte-offset register bus with 32-bit data.
package extint_pkg;

    localparam int REG_ADDR_W = 12;
    localparam int REG_DATA_W = 32;
    localparam int SENSE_W    = 4;

    // Register byte offsets
    localparam logic [REG_ADDR_W-1:0] OFS_REQ      = 12'h000;
    localparam logic [REG_ADDR_W-1:0] OFS_EN_CLR   = 12'h004;
    localparam logic [REG_ADDR_W-1:0] OFS_EN_SET   = 12'h008;
    localparam logic [REG_ADDR_W-1:0] OFS_DET      = 12'h100;
    localparam logic [REG_ADDR_W-1:0] OFS_MON      = 12'h104;
    localparam logic [REG_ADDR_W-1:0] OFS_CFG_BASE = 12'h180;

    // Sense codes held in configuration bits 3:0
    localparam logic [SENSE_W-1:0] SENSE_LOW  = 4'h1;
    localparam logic [SENSE_W-1:0] SENSE_HIGH = 4'h2;
    localparam logic [SENSE_W-1:0] SENSE_FALL = 4'h4;
    localparam logic [SENSE_W-1:0] SENSE_RISE = 4'h8;
    localparam logic [SENSE_W-1:0] SENSE_BOTH = 4'hC;

    localparam logic [REG_DATA_W-1:0] CFG_RESET = 32'h0000_0002;

    typedef enum logic [2:0] {
        MODE_NONE,
        MODE_LOW,
        MODE_HIGH,
        MODE_FALL,
        MODE_RISE,
        MODE_BOTH
    } sense_mode_e;

    // Map a raw sense code to a detection mode; unknown codes detect nothing.
    function automatic sense_mode_e decode_sense(input logic [SENSE_W-1:0] code);
        case (code)
            SENSE_LOW:  return MODE_LOW;
            SENSE_HIGH: return MODE_HIGH;
            SENSE_FALL: return MODE_FALL;
            SENSE_RISE: return MODE_RISE;
            SENSE_BOTH: return MODE_BOTH;
            default:    return MODE_NONE;
        endcase
    endfunction

endpackage

// File: rtl/extint_sync.sv
`timescale 1ns/1ps
// Module: extint_sync
// Two-stage synchroniser for a vector of asynchronous pins. Each bit is
// treated independently; no multi-bit coherency is assumed or provided.
module extint_sync #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    // Shift the raw pins through two flops to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;

endmodule

// File: rtl/extint_pin_detect.sv
`timescale 1ns/1ps
// Module: extint_pin_detect
// Event detection and sticky status for one pin. Takes an already
// synchronised level. Edges come from comparing that level with its value
// one clock earlier. A clear request and a new event in the same cycle
// leave the status set.
module extint_pin_detect
    import extint_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lvl_i,
    input  sense_mode_e mode_i,
    input  logic        clr_i,
    output logic        det_o
);

    logic prev_q;
    logic det_q;
    logic rise;
    logic fall;
    logic evt;

    // Remember the previous synchronised level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl_i;
    end

    assign rise = lvl_i & ~prev_q;
    assign fall = ~lvl_i & prev_q;

    // Select the event condition for the configured mode.
    always_comb begin
        case (mode_i)
            MODE_LOW:  evt = ~lvl_i;
            MODE_HIGH: evt = lvl_i;
            MODE_FALL: evt = fall;
            MODE_RISE: evt = rise;
            MODE_BOTH: evt = rise | fall;
            default:   evt = 1'b0;
        endcase
    end

    // Sticky status: clear on request, a same-cycle event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) det_q <= 1'b0;
        else        det_q <= (det_q & ~clr_i) | evt;
    end

    assign det_o = det_q;

endmodule

// File: rtl/extint_regs.sv
`timescale 1ns/1ps
// Module: extint_regs
// Software-written state: the per-pin enable mask and the per-pin 32-bit
// configuration words. The write strobes are decoded by the parent; the
// set and clear strobes are assumed never to be active together.
module extint_regs
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en_set_we,
    input  logic                                en_clr_we,
    input  logic [NUM_PINS-1:0]                 en_mask_i,
    input  logic [NUM_PINS-1:0]                 cfg_we,
    input  logic [REG_DATA_W-1:0]               wdata_i,
    output logic [NUM_PINS-1:0]                 en_o,
    output logic [NUM_PINS-1:0][REG_DATA_W-1:0] cfg_o
);

    logic [NUM_PINS-1:0] en_q;

    // Apply write-one-to-set and write-one-to-clear to the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_q <= '0;
        else if (en_set_we) en_q <= en_q | en_mask_i;
        else if (en_clr_we) en_q <= en_q & ~en_mask_i;
    end

    assign en_o = en_q;

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_cfg
        logic [REG_DATA_W-1:0] cfg_q;

        // Hold the full configuration word of pin n.
        always_ff @(posedge clk) begin
            if (!rst_n)         cfg_q <= CFG_RESET;
            else if (cfg_we[n]) cfg_q <= wdata_i;
        end

        assign cfg_o[n] = cfg_q;
    end

endmodule

// File: rtl/extint_ctrl.sv
`timescale 1ns/1ps
// Module: extint_ctrl (top)
// External interrupt pin controller: synchronises NUM_PINS pins, detects
// the event chosen per pin, keeps sticky detect bits, and drives one
// request output per pin gated by an enable mask. Assumes 1 <= NUM_PINS
// <= 32 and a single-cycle register write strobe.
module extint_ctrl
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PINS-1:0]   pin_i,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [REG_DATA_W-1:0] bus_wdata,
    output logic [REG_DATA_W-1:0] bus_rdata,
    output logic [NUM_PINS-1:0]   irq_o
);

    localparam int CFG_STRIDE = 4;

    logic [NUM_PINS-1:0]                 pin_lvl;
    logic [NUM_PINS-1:0]                 det_q;
    logic [NUM_PINS-1:0]                 en_q;
    logic [NUM_PINS-1:0][REG_DATA_W-1:0] cfg_q;
    logic [NUM_PINS-1:0]                 cfg_we;
    logic [NUM_PINS-1:0]                 det_clr;
    logic                                en_set_we;
    logic                                en_clr_we;
    logic                                det_we;

    assign en_set_we = bus_we && (bus_addr == OFS_EN_SET);
    assign en_clr_we = bus_we && (bus_addr == OFS_EN_CLR);
    assign det_we    = bus_we && (bus_addr == OFS_DET);
    assign det_clr   = det_we ? bus_wdata[NUM_PINS-1:0] : '0;

    extint_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_lvl)
    );

    extint_regs #(.NUM_PINS(NUM_PINS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_set_we (en_set_we),
        .en_clr_we (en_clr_we),
        .en_mask_i (bus_wdata[NUM_PINS-1:0]),
        .cfg_we    (cfg_we),
        .wdata_i   (bus_wdata),
        .en_o      (en_q),
        .cfg_o     (cfg_q)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        localparam logic [REG_ADDR_W-1:0] CFG_OFS =
            OFS_CFG_BASE + REG_ADDR_W'(n * CFG_STRIDE);

        assign cfg_we[n] = bus_we && (bus_addr == CFG_OFS);

        extint_pin_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (pin_lvl[n]),
            .mode_i (decode_sense(cfg_q[n][SENSE_W-1:0])),
            .clr_i  (det_clr[n]),
            .det_o  (det_q[n])
        );
    end

    assign irq_o = det_q & en_q;

    // Combinational register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_REQ:    bus_rdata = REG_DATA_W'(irq_o);
            OFS_EN_CLR: bus_rdata = REG_DATA_W'(en_q);
            OFS_DET:    bus_rdata = REG_DATA_W'(det_q);
            OFS_MON:    bus_rdata = REG_DATA_W'(pin_lvl);
            default: begin
                for (int n = 0; n < NUM_PINS; n++) begin
                    if (bus_addr == OFS_CFG_BASE + REG_ADDR_W'(n * CFG_STRIDE))
                        bus_rdata = cfg_q[n];
                end
            end
        endcase
    end

endmodule

// File: rtl/extint_ctrl_chk.sv
`timescale 1ns/1ps
// Module: extint_ctrl_chk
// Assertion checker attached to extint_ctrl. Observes the ports plus the
// enable mask, detect bits and synchronised levels. Assumes pins change
// no more than once per clock, as with a synchronous stimulus source.
module extint_ctrl_chk
    import extint_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PINS-1:0]   pin_i,
    input logic                  bus_we,
    input logic [REG_ADDR_W-1:0] bus_addr,
    input logic [REG_DATA_W-1:0] bus_wdata,
    input logic [NUM_PINS-1:0]   irq_o,
    input logic [NUM_PINS-1:0]   det_q,
    input logic [NUM_PINS-1:0]   en_q,
    input logic [NUM_PINS-1:0]   pin_lvl
);

    logic [1:0] warm_q;

    // Count clocks since reset, saturating, to qualify the monitor lag check.
    always_ff @(posedge clk) begin
        if (!rst_n)            warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~en_q) == '0);

    assert_det_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_addr == OFS_DET) |=> ((~det_q & $past(det_q)) == '0));

    assert_en_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_EN_SET) |=>
        ((en_q & $past(bus_wdata[NUM_PINS-1:0])) == $past(bus_wdata[NUM_PINS-1:0])));

    assert_en_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_EN_CLR) |=>
        ((en_q & $past(bus_wdata[NUM_PINS-1:0])) == '0));

    assert_monitor_lag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= 2'd2) |-> (pin_lvl == $past(pin_i, 2)));

endmodule

bind extint_ctrl extint_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pin_i),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .irq_o     (irq_o),
    .det_q     (det_q),
    .en_q      (en_q),
    .pin_lvl   (pin_lvl)
);

// File: tb/extint_ctrl_bench.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values, a monitor process
// pops and compares them at the falling clock edge.
module extint_ctrl_bench;
    import extint_pkg::*;

    localparam int N = 8;

    typedef struct {
        bit          is_irq;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_i = '0;
    logic          bus_we = 1'b0;
    logic [11:0]   bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [N-1:0]  irq_o;
    logic          chk_valid = 1'b0;
    item_t         sb_q[$];
    int            n_checks = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    extint_ctrl #(.NUM_PINS(N)) u_extint_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_i     (pin_i),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_o     (irq_o)
    );

    // Monitor: pop one expected item per check cycle and compare mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            if (chk_valid && sb_q.size() > 0) begin
                item_t it;
                logic [31:0] act;
                it = sb_q.pop_front();
                act = it.is_irq ? 32'(irq_o) : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        cyc();
        bus_we = 1'b0;
    endtask

    task automatic rd_exp(input logic [11:0] a, input logic [31:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b0; it.exp = e; it.tag = tag;
        bus_addr = a;
        sb_q.push_back(it);
        chk_valid = 1'b1;
        cyc();
        chk_valid = 1'b0;
    endtask

    task automatic irq_exp(input logic [N-1:0] e, input string tag);
        item_t it;
        it.is_irq = 1'b1; it.exp = 32'(e); it.tag = tag;
        sb_q.push_back(it);
        chk_valid = 1'b1;
        cyc();
        chk_valid = 1'b0;
    endtask

    task automatic set_pins(input logic [N-1:0] p);
        pin_i = p;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        cyc();
        // R1 reset state
        rd_exp(OFS_EN_CLR, 32'h0, "R1 enable after reset");
        rd_exp(OFS_DET, 32'h0, "R1 detect after reset");
        rd_exp(OFS_REQ, 32'h0, "R1 request after reset");
        rd_exp(OFS_CFG_BASE, 32'h2, "R1 cfg0 reset");
        rd_exp(OFS_CFG_BASE + 12'h1C, 32'h2, "R1 cfg7 reset");
        irq_exp('0, "R1 irq after reset");

        // Idle levels, then configure sense codes (R2)
        set_pins(8'h06);
        wait_cyc(4);
        wr(OFS_CFG_BASE + 12'h04, 32'h1);
        wr(OFS_CFG_BASE + 12'h08, 32'h4);
        wr(OFS_CFG_BASE + 12'h0C, 32'hDEADBE08);
        wr(OFS_CFG_BASE + 12'h10, 32'hC);
        wr(OFS_CFG_BASE + 12'h14, 32'h3);
        rd_exp(OFS_CFG_BASE + 12'h0C, 32'hDEADBE08, "R2 cfg3 readback");
        rd_exp(OFS_CFG_BASE + 12'h14, 32'h3, "R2 cfg5 readback");
        rd_exp(OFS_CFG_BASE + 12'h20, 32'h0, "R12 absent cfg8 reads 0");
        wait_cyc(3);
        wr(OFS_DET, 32'hFF);
        rd_exp(OFS_DET, 32'h0, "R8 detect cleared");

        // Enables (R9, R12)
        wr(OFS_EN_SET, 32'hFFFFFF00);
        rd_exp(OFS_EN_CLR, 32'h0, "R12 upper enable bits ignored");
        wr(OFS_EN_SET, 32'hFF);
        rd_exp(OFS_EN_CLR, 32'hFF, "R9 enable set");
        wr(OFS_EN_CLR, 32'h0);
        rd_exp(OFS_EN_CLR, 32'hFF, "R9 zero clear no effect");
        wr(OFS_EN_CLR, 32'h80);
        rd_exp(OFS_EN_CLR, 32'h7F, "R9 enable clear");

        // R3 high level, R13 latency
        set_pins(8'h07);
        wait_cyc(2);
        rd_exp(OFS_DET, 32'h0, "R13 not yet after two edges");
        rd_exp(OFS_DET, 32'h1, "R13 set on third edge");
        irq_exp(8'h01, "R10 irq pin0");
        rd_exp(OFS_REQ, 32'h1, "R10 request pin0");
        wr(OFS_DET, 32'h1);
        rd_exp(OFS_DET, 32'h1, "R3 level re-sets after clear");
        set_pins(8'h06);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h1, "R3 sticky after level drops");
        wr(OFS_DET, 32'h1);
        rd_exp(OFS_DET, 32'h0, "R3 cleared after drop");
        irq_exp(8'h00, "R10 irq gone after clear");

        // R4 low level
        set_pins(8'h04);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h2, "R4 low level detect");
        set_pins(8'h06);
        wait_cyc(3);
        wr(OFS_DET, 32'h2);
        rd_exp(OFS_DET, 32'h0, "R4 cleared");

        // R6 falling edge
        set_pins(8'h02);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h4, "R6 falling detect");
        wr(OFS_DET, 32'h4);
        wait_cyc(2);
        rd_exp(OFS_DET, 32'h0, "R6 no re-set while low");
        set_pins(8'h06);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h0, "R6 rise ignored in falling mode");

        // R5 rising edge
        set_pins(8'h0E);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h8, "R5 rising detect");
        wr(OFS_DET, 32'h8);
        wait_cyc(2);
        rd_exp(OFS_DET, 32'h0, "R5 no re-set while high");
        set_pins(8'h06);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h0, "R5 fall ignored in rising mode");

        // R6 both edges
        set_pins(8'h16);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h10, "R6 both mode rise");
        wr(OFS_DET, 32'h10);
        set_pins(8'h06);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h10, "R6 both mode fall");
        wr(OFS_DET, 32'h10);
        rd_exp(OFS_DET, 32'h0, "R6 both cleared");

        // R7 unknown code
        set_pins(8'h26);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h0, "R7 code 0x3 high ignored");
        set_pins(8'h06);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h0, "R7 code 0x3 low ignored");

        // R8 event and clear in same cycle: set wins
        set_pins(8'h16);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h10, "R8 pre-set pin4");
        set_pins(8'h06);
        wait_cyc(2);
        wr(OFS_DET, 32'h10);
        rd_exp(OFS_DET, 32'h10, "R8 set wins over clear");
        wr(OFS_DET, 32'h10);
        rd_exp(OFS_DET, 32'h0, "R8 cleared afterwards");

        // R10 request masking
        set_pins(8'h46);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'h40, "R3 pin6 high detect");
        rd_exp(OFS_REQ, 32'h40, "R10 request pin6");
        set_pins(8'hC6);
        wait_cyc(3);
        rd_exp(OFS_DET, 32'hC0, "R3 pin7 detected while disabled");
        rd_exp(OFS_REQ, 32'h40, "R10 disabled pin masked");
        irq_exp(8'h40, "R10 irq masked");
        wr(OFS_EN_SET, 32'h80);
        rd_exp(OFS_REQ, 32'hC0, "R10 request after enable");
        irq_exp(8'hC0, "R10 irq after enable");
        wr(OFS_EN_CLR, 32'h40);
        rd_exp(OFS_REQ, 32'h80, "R10 request after disable");
        irq_exp(8'h80, "R10 irq after disable");

        // R11 monitor
        rd_exp(OFS_MON, 32'hC6, "R11 monitor steady");
        set_pins(8'h39);
        wait_cyc(2);
        rd_exp(OFS_MON, 32'h39, "R11 monitor after two edges");

        wait_cyc(2);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule